// File: doc/BRIEF.md
# Hysteretic Interval Selector Encoder

This block models, in digital form, the interval selector of one input of an interpolating controller. An unsigned input sample is compared against a programmable table of L−1 threshold values. Each comparison keeps its own hysteresis state, so the sample must pass a threshold by a programmable margin before that comparison flips. The comparison states form a thermometer code. A priority coder takes the highest asserted bit and turns it into an interval index, which is emitted both in Gray code and in binary.

The registered Gray index is decoded back into a one-hot select. That select picks the stored center value of the active interval, which is the value used to program the antecedent stage downstream. Thresholds, centers and the two margins are written through a plain write-only parallel port. Because the table is generic, one instance's contents can equally describe a partition shared by several inputs.

Top module: `interval_gray_selector`

## Requirements
- R1: The binary index equals the highest position j (0 to L−2) whose comparison state is high, or 0 when none is high; a low state below a high one (a bubble, e.g. from non-ascending thresholds) is ignored.
- R2: A comparison state that is low goes high on a strobed sample only when sample > threshold + positive margin (computed without overflow).
- R3: A comparison state that is high goes low on a strobed sample only when sample < threshold − negative margin (computed without underflow).
- R4: Reset clears all comparison states, both indices, the valid output and all table registers; the first strobed sample after reset sets each state to (sample > threshold) with no margin applied, whatever the margin registers hold.
- R5: The Gray index equals bin ^ (bin >> 1); when the binary index moves by one between consecutive valid outputs, exactly one Gray bit changes.
- R6: The center output equals the stored center of the interval selected by decoding the Gray index, and follows a write to that center entry.
- R7: out_valid is high for exactly the cycle after a cycle with sample_valid high; without a strobe the indices and comparison states hold, whatever sample_in does.
- R8: Register map on cfg_we: address j (0..L−2) writes threshold j, address L−1+j writes center j, address 2(L−1) writes the positive margin, address 2(L−1)+1 writes the negative margin.
- R9: With both margins zero a state rises when sample > threshold, falls when sample < threshold, and holds when sample equals threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe: evaluate sample_in this cycle |
| sample_in | input | DW | Unsigned input sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| idx_gray | output | IW | Gray-coded interval index |
| idx_bin | output | IW | Binary interval index |
| center_out | output | DW | Center value of the active interval |
| out_valid | output | 1 | High the cycle after a strobe |

## Verification
A wrong comparison state is invisible until a later strobe moves the sample near that threshold, where the index then differs by one interval from the expected value in the cycle after the strobe; the bench therefore walks the sample across each threshold in both directions with and without margins. A wrong Gray encoding or decode shows at once in the same cycle as a mismatch between idx_gray, idx_bin and center_out. Ramps check that every single-interval step flips one Gray bit, and a deliberately non-ascending table exposes a coder that does not take the highest bit.

// File: rtl/interval_gray_selector.sv
module interval_gray_selector #(
  parameter int NUM_LABELS = 8,
  parameter int DW = 8,
  localparam int NTH = NUM_LABELS - 1,
  localparam int IW = $clog2(NTH),
  localparam int AW = $clog2(2 * NTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [IW-1:0] idx_gray,
  output logic [IW-1:0] idx_bin,
  output logic [DW-1:0] center_out,
  output logic          out_valid
);

  localparam int A_MPOS = 2 * NTH;
  localparam int A_MNEG = 2 * NTH + 1;

  logic [DW-1:0] thr_q [NTH];
  logic [DW-1:0] cen_q [NTH];
  logic [DW-1:0] mpos_q, mneg_q;
  logic [NTH-1:0] st_q, st_n;
  logic primed_q;
  logic [IW-1:0] bin_n, dec_bin;
  logic [NTH-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NTH; j++) begin
        thr_q[j] <= '0;
        cen_q[j] <= '0;
      end
      mpos_q <= '0;
      mneg_q <= '0;
    end else if (cfg_we) begin
      for (int j = 0; j < NTH; j++) begin
        if (int'(cfg_addr) == j) thr_q[j] <= cfg_wdata;
        if (int'(cfg_addr) == NTH + j) cen_q[j] <= cfg_wdata;
      end
      if (int'(cfg_addr) == A_MPOS) mpos_q <= cfg_wdata;
      if (int'(cfg_addr) == A_MNEG) mneg_q <= cfg_wdata;
    end
  end

  always_comb begin
    for (int j = 0; j < NTH; j++) begin
      if (!primed_q)
        st_n[j] = sample_in > thr_q[j];
      else if (st_q[j])
        st_n[j] = !(({1'b0, sample_in} + {1'b0, mneg_q}) < {1'b0, thr_q[j]});
      else
        st_n[j] = {1'b0, sample_in} > ({1'b0, thr_q[j]} + {1'b0, mpos_q});
    end
  end

  always_comb begin
    bin_n = '0;
    for (int j = 0; j < NTH; j++)
      if (st_n[j]) bin_n = IW'(j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      primed_q  <= 1'b0;
      idx_bin   <= '0;
      idx_gray  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= sample_valid;
      if (sample_valid) begin
        st_q     <= st_n;
        primed_q <= 1'b1;
        idx_bin  <= bin_n;
        idx_gray <= bin_n ^ (bin_n >> 1);
      end
    end
  end

  always_comb begin
    dec_bin[IW-1] = idx_gray[IW-1];
    for (int i = IW - 2; i >= 0; i--)
      dec_bin[i] = dec_bin[i+1] ^ idx_gray[i];
  end

  always_comb begin
    center_out = '0;
    for (int j = 0; j < NTH; j++) begin
      sel[j] = (dec_bin == IW'(j));
      if (sel[j]) center_out = center_out | cen_q[j];
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_bin) < NTH); // R1
  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel)); // R6
  AST_GRAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dec_bin == idx_bin); // R5
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && ((bin_n == idx_bin + IW'(1)) || (idx_bin == bin_n + IW'(1))))
    |=> ($countones(idx_gray ^ $past(idx_gray)) == 1)); // R5
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid); // R7
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(idx_bin) && $stable(idx_gray) && $stable(st_q))); // R7

endmodule

// File: tb/interval_gray_selector_tb_top.sv
module interval_gray_selector_tb_top;
  localparam int L = 8;
  localparam int DW = 8;
  localparam int NTH = L - 1;
  localparam int IW = $clog2(NTH);
  localparam int AW = $clog2(2 * NTH + 2);

  logic clk = 0, rst_n = 0, sample_valid = 0, cfg_we = 0;
  logic [DW-1:0] sample_in = '0, cfg_wdata = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [IW-1:0] idx_gray, idx_bin;
  logic [DW-1:0] center_out;
  logic out_valid;

  int n_chk = 0, n_bad = 0;
  int thr_m [NTH];
  int cen_m [NTH];
  int mp_m = 0, mn_m = 0;
  bit st_m [NTH];
  bit primed_m = 0;

  always #4 clk = ~clk;

  interval_gray_selector #(.NUM_LABELS(L), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .idx_gray(idx_gray), .idx_bin(idx_bin), .center_out(center_out), .out_valid(out_valid));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(addr); cfg_wdata = DW'(data);
    @(negedge clk);
    cfg_we = 0;
    if (addr < NTH) thr_m[addr] = data;
    else if (addr < 2 * NTH) cen_m[addr - NTH] = data;
    else if (addr == 2 * NTH) mp_m = data;
    else mn_m = data;
  endtask

  function automatic int exp_bin();
    int b = 0;
    for (int j = 0; j < NTH; j++) if (st_m[j]) b = j;
    return b;
  endfunction

  task automatic check_outs(string req);
    int b = exp_bin();
    check({req, " bin"}, int'(idx_bin), b);
    check({req, " gray"}, int'(idx_gray), b ^ (b >> 1));
    check({req, " center"}, int'(center_out), cen_m[b]);
  endtask

  task automatic apply(int x, string req);
    for (int j = 0; j < NTH; j++) begin
      if (!primed_m) st_m[j] = x > thr_m[j];
      else if (st_m[j]) st_m[j] = !(x + mn_m < thr_m[j]);
      else st_m[j] = x > thr_m[j] + mp_m;
    end
    primed_m = 1;
    @(negedge clk);
    sample_in = DW'(x); sample_valid = 1;
    @(negedge clk);
    sample_valid = 0;
    check({req, " valid"}, int'(out_valid), 1);
    check_outs(req);
  endtask

  task automatic t_reset();
    check("R4 reset valid", int'(out_valid), 0);
    check("R4 reset bin", int'(idx_bin), 0);
    check("R4 reset gray", int'(idx_gray), 0);
    check("R4 reset center", int'(center_out), 0);
  endtask

  task automatic t_load();
    for (int j = 0; j < NTH; j++) wr(j, 20 + 30 * j);
    for (int j = 0; j < NTH; j++) wr(NTH + j, 7 + 13 * j);
    wr(2 * NTH, 5); wr(2 * NTH + 1, 5);
  endtask

  task automatic t_first_plain();
    apply(112, "R4 first sample plain");
    check("R4 first idx", int'(idx_bin), 3);
  endtask

  task automatic t_hyst();
    apply(108, "R3 hold above low margin");
    check("R3 idx stays", int'(idx_bin), 3);
    apply(104, "R3 fall below margin");
    check("R3 idx falls", int'(idx_bin), 2);
    apply(113, "R2 hold below high margin");
    check("R2 idx stays", int'(idx_bin), 2);
    apply(116, "R2 rise above margin");
    check("R2 idx rises", int'(idx_bin), 3);
  endtask

  task automatic t_ramp(string req);
    int pb = int'(idx_bin), pg = int'(idx_gray);
    for (int x = 0; x <= 255; x += 3) begin
      apply(x, {req, " ramp up R1"});
      if (int'(idx_bin) == pb + 1 || int'(idx_bin) == pb - 1)
        check("R5 one-bit step up", $countones(idx_gray ^ IW'(pg)), 1);
      pb = int'(idx_bin); pg = int'(idx_gray);
    end
    for (int x = 255; x >= 0; x -= 3) begin
      apply(x, {req, " ramp down R1"});
      if (int'(idx_bin) == pb + 1 || int'(idx_bin) == pb - 1)
        check("R5 one-bit step down", $countones(idx_gray ^ IW'(pg)), 1);
      pb = int'(idx_bin); pg = int'(idx_gray);
    end
  endtask

  task automatic t_zero_margin();
    wr(2 * NTH, 0); wr(2 * NTH + 1, 0);
    apply(100, "R9 setup");
    apply(110, "R9 equal from below holds");
    check("R9 eq below", int'(idx_bin), 2);
    apply(111, "R9 rise");
    check("R9 rise idx", int'(idx_bin), 3);
    apply(110, "R9 equal from above holds");
    check("R9 eq above", int'(idx_bin), 3);
    apply(109, "R9 fall");
    check("R9 fall idx", int'(idx_bin), 2);
  endtask

  task automatic t_hold();
    int b = int'(idx_bin);
    @(negedge clk);
    sample_in = 8'd250;
    repeat (3) @(negedge clk);
    check("R7 no strobe valid", int'(out_valid), 0);
    check("R7 no strobe hold", int'(idx_bin), b);
    sample_in = 8'd0;
    @(negedge clk);
    check_outs("R7 hold after input swing");
    apply(109, "R7 state kept without strobe");
  endtask

  task automatic t_center_write();
    int b = int'(idx_bin);
    wr(NTH + b, 201);
    check("R6 R8 center follows write", int'(center_out), 201);
  endtask

  task automatic t_bubble();
    wr(2, 250);
    apply(150, "R1 bubble");
    check("R1 bubble idx", int'(idx_bin), 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < NTH; j++) begin thr_m[j] = 0; cen_m[j] = 0; st_m[j] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_load();
    t_first_plain();
    t_hyst();
    t_ramp("margin5");
    t_zero_margin();
    t_ramp("margin0");
    t_hold();
    t_center_write();
    t_bubble();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule